// File: doc/BRIEF.md
# Per-Tile Attribute Substitution Unit

This unit sits between a tile-based video fetch engine and the memory that holds its nametables and pattern data. It contains a 1 KB expansion RAM, one byte for each tile position of a nametable, which the CPU reaches through a small register and RAM port. The behaviour of that port is set by a 2-bit RAM mode register.

In the per-tile attribute mode, while the in-frame input is high, the unit watches every nametable fetch. It then rewrites the three fetches that follow. The first becomes a palette byte taken from the expansion RAM entry of that tile. The next two become pattern fetches from a 4 KB pattern bank that the same entry selects. Each tile therefore gets its own palette and its own pattern bank, and the shared attribute table is not used. In every other case, fetches pass through to memory unchanged.

The returned fetch data comes from a registered multiplexer. It is valid on the cycle after the fetch address is presented.

Top module: `exattr_subst`

## Requirements
- R1: While reset is asserted, and after it is released, `fetch_rvalid`, `fetch_rdata` and `cpu_rdata_oe` are 0. The RAM mode, the upper-bank register, the countdown, the latched tile offset and the latched bank are all cleared, so a non-nametable fetch made after reset passes through.
- R2: A fetch is a nametable fetch when `fetch_addr` is in 0x2000–0x2FFF and `fetch_addr[9:0]` is below 0x3C0. A nametable fetch always passes through (`mem_ext` = 0, `mem_addr` = `fetch_addr`). Every other address, including 0x23C0–0x23FF and addresses outside 0x2000–0x2FFF, counts as a non-nametable fetch.
- R3: When substitution is active, the first non-nametable fetch after a nametable fetch returns {p,p,p,p}. Here p is bits 7:6 of the expansion RAM byte at offset `fetch_addr[9:0]` of that nametable fetch.
- R4: On that same fetch, the unit latches the pattern bank ({upper[1:0], byte[5:0]}) mod NUM_BANKS. The default NUM_BANKS is 32.
- R5: The second and third non-nametable fetches after a nametable fetch drive `mem_addr` = bank·4096 + `fetch_addr[11:0]` with `mem_ext` = 1, and return `mem_rdata`. The fourth such fetch passes through again.
- R6: Substitution is active only when the RAM mode is 1 and `in_frame` is 1. Otherwise every fetch passes through with `mem_ext` = 0.
- R7: In RAM modes 0 and 1, CPU reads of the RAM return open bus (`cpu_rdata_oe` = 0). A CPU write stores the data when `in_frame` is 1, and stores 0x00 when `in_frame` is 0.
- R8: In RAM mode 2, CPU reads return the stored byte (`cpu_rdata_oe` = 1) and CPU writes store the data.
- R9: In RAM mode 3, CPU writes to the RAM are ignored and CPU reads return the stored byte.
- R10: `fetch_rvalid` is high exactly one cycle after a cycle with `fetch_valid` high. `fetch_rdata` is valid in that cycle.
- R11: `cpu_addr[10]` = 0 selects the RAM at `cpu_addr[9:0]`. `cpu_addr[10]` = 1 selects a register: with `cpu_addr[0]` = 0 it is the RAM mode (`cpu_wdata[1:0]`), and with `cpu_addr[0]` = 1 it is the upper-bank register (`cpu_wdata[1:0]`). Register reads return open bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_frame | input | 1 | High while the video engine is rendering |
| fetch_valid | input | 1 | A video fetch is presented this cycle |
| fetch_addr | input | 14 | Video fetch address |
| fetch_rdata | output | 8 | Fetch result, one cycle after the fetch |
| fetch_rvalid | output | 1 | `fetch_rdata` holds a new result |
| mem_addr | output | 20 | Address to video/pattern memory |
| mem_ext | output | 1 | `mem_addr` is an absolute pattern ROM address chosen by this unit |
| mem_rdata | input | 8 | Memory data for `mem_addr`, combinational |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 11 | CPU address: RAM or register select |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, one cycle after the read |
| cpu_rdata_oe | output | 1 | CPU read data is driven (0 means open bus) |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle response timing;
- that a nametable fetch is never rewritten;
- that a rewritten fetch only happens in mode 1 while in frame, and always lands inside the populated banks;
- that a rewritten fetch returns exactly the memory word;
- that CPU read open-bus behaviour follows the mode.

Only the bench scenarios can show the rest:
- the palette value and the bank arithmetic, including the modulo and the upper-bank register;
- the exact three-fetch window and where it ends;
- the zero-write rule outside the frame, the ignored writes in read-only mode, and the clearing of the countdown by a reset in the middle of a sequence.

// File: rtl/exattr_pkg.sv
`timescale 1ns/1ps
package exattr_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'd0,
        MODE_EXATTR = 2'd1,
        MODE_RW     = 2'd2,
        MODE_RO     = 2'd3
    } ram_mode_e;

    // Replicate a 2-bit palette code into every 2-bit lane of a byte
    function automatic logic [7:0] spread_pal(input logic [1:0] p);
        return {p, p, p, p};
    endfunction

endpackage

// File: rtl/exattr_ram.sv
`timescale 1ns/1ps
module exattr_ram #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata_a = store[raddr_a];
    assign rdata_b = store[raddr_b];
endmodule

// File: rtl/exattr_ctrl.sv
`timescale 1ns/1ps
module exattr_ctrl
    import exattr_pkg::*;
#(
    parameter int OFF_W   = 10,
    parameter int UPPER_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_frame,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [OFF_W:0]     cpu_addr,
    input  logic [7:0]         cpu_wdata,
    input  logic [7:0]         ram_rdata,
    output logic               ram_we,
    output logic [OFF_W-1:0]   ram_addr,
    output logic [7:0]         ram_wdata,
    output ram_mode_e          mode,
    output logic [UPPER_W-1:0] upper,
    output logic [7:0]         cpu_rdata,
    output logic               cpu_rdata_oe
);
    typedef struct packed {
        ram_mode_e          mode;
        logic [UPPER_W-1:0] upper;
        logic [7:0]         rdata;
        logic               oe;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  reg_sel;

    assign reg_sel  = cpu_addr[OFF_W];
    assign ram_addr = cpu_addr[OFF_W-1:0];

    always_comb begin
        st_d       = st_q;
        st_d.oe    = 1'b0;
        st_d.rdata = '0;
        ram_we     = 1'b0;
        ram_wdata  = cpu_wdata;
        if (cpu_wr && reg_sel) begin
            if (!cpu_addr[0]) st_d.mode  = ram_mode_e'(cpu_wdata[1:0]);
            else              st_d.upper = cpu_wdata[UPPER_W-1:0];
        end
        if (cpu_wr && !reg_sel && st_q.mode != MODE_RO) begin
            ram_we = 1'b1;
            if ((st_q.mode == MODE_PLAIN || st_q.mode == MODE_EXATTR) && !in_frame)
                ram_wdata = '0;
        end
        if (cpu_rd && !reg_sel && (st_q.mode == MODE_RW || st_q.mode == MODE_RO)) begin
            st_d.oe    = 1'b1;
            st_d.rdata = ram_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_PLAIN, upper: '0, rdata: '0, oe: 1'b0};
        else        st_q <= st_d;
    end

    assign mode         = st_q.mode;
    assign upper        = st_q.upper;
    assign cpu_rdata    = st_q.rdata;
    assign cpu_rdata_oe = st_q.oe;
endmodule

// File: rtl/exattr_fetch.sv
`timescale 1ns/1ps
module exattr_fetch
    import exattr_pkg::*;
#(
    parameter int OFF_W     = 10,
    parameter int UPPER_W   = 2,
    parameter int NUM_BANKS = 32,
    parameter int VADDR_W   = 14,
    localparam int BANK_W     = 6 + UPPER_W,
    localparam int MEM_ADDR_W = BANK_W + 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_frame,
    input  ram_mode_e             mode,
    input  logic [UPPER_W-1:0]    upper,
    input  logic                  fetch_valid,
    input  logic [VADDR_W-1:0]    fetch_addr,
    input  logic [7:0]            ram_rdata,
    output logic [OFF_W-1:0]      ram_addr,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic                  mem_ext,
    input  logic [7:0]            mem_rdata,
    output logic [7:0]            fetch_rdata,
    output logic                  fetch_rvalid
);
    localparam logic [OFF_W-1:0] ATTR_BASE = OFF_W'(10'h3C0);
    localparam logic [BANK_W:0]  NB        = (BANK_W+1)'(NUM_BANKS);

    typedef struct packed {
        logic [1:0]        cnt;
        logic [OFF_W-1:0]  off;
        logic [BANK_W-1:0] bank;
        logic [7:0]        rdata;
        logic              rvalid;
    } fetch_t;

    fetch_t          st_d, st_q;
    logic            active, is_nt, pal_step, pat_step;
    logic [BANK_W:0] bank_wide;

    always_comb begin
        active    = (mode == MODE_EXATTR) && in_frame;
        is_nt     = (fetch_addr[VADDR_W-1:VADDR_W-2] == 2'b10) && (fetch_addr[OFF_W-1:0] < ATTR_BASE);
        pal_step  = active && fetch_valid && !is_nt && (st_q.cnt == 2'd3);
        pat_step  = active && fetch_valid && !is_nt && (st_q.cnt == 2'd2 || st_q.cnt == 2'd1);
        ram_addr  = st_q.off;
        bank_wide = {1'b0, upper, ram_rdata[5:0]} % NB;
        mem_ext   = pat_step;
        mem_addr  = pat_step ? {st_q.bank, fetch_addr[11:0]}
                             : {{(MEM_ADDR_W-VADDR_W){1'b0}}, fetch_addr};

        st_d        = st_q;
        st_d.rvalid = fetch_valid;
        if (fetch_valid) st_d.rdata = pal_step ? spread_pal(ram_rdata[7:6]) : mem_rdata;
        if (pal_step) st_d.bank = bank_wide[BANK_W-1:0];
        if (active && fetch_valid) begin
            if (is_nt) begin
                st_d.off = fetch_addr[OFF_W-1:0];
                st_d.cnt = 2'd3;
            end else if (st_q.cnt != 2'd0) begin
                st_d.cnt = st_q.cnt - 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_rdata  = st_q.rdata;
    assign fetch_rvalid = st_q.rvalid;
endmodule

// File: rtl/exattr_subst.sv
`timescale 1ns/1ps
module exattr_subst
    import exattr_pkg::*;
#(
    parameter int RAM_DEPTH = 1024,
    parameter int UPPER_W   = 2,
    parameter int NUM_BANKS = 32,
    localparam int OFF_W      = $clog2(RAM_DEPTH),
    localparam int VADDR_W    = 14,
    localparam int BANK_W     = 6 + UPPER_W,
    localparam int MEM_ADDR_W = BANK_W + 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_frame,
    input  logic                  fetch_valid,
    input  logic [VADDR_W-1:0]    fetch_addr,
    output logic [7:0]            fetch_rdata,
    output logic                  fetch_rvalid,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic                  mem_ext,
    input  logic [7:0]            mem_rdata,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [OFF_W:0]        cpu_addr,
    input  logic [7:0]            cpu_wdata,
    output logic [7:0]            cpu_rdata,
    output logic                  cpu_rdata_oe
);
    ram_mode_e          mode;
    logic [UPPER_W-1:0] upper;
    logic               ram_we;
    logic [OFF_W-1:0]   ram_cpu_addr, ram_vid_addr;
    logic [7:0]         ram_wdata, ram_cpu_rdata, ram_vid_rdata;

    exattr_ram #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_cpu_addr), .wdata(ram_wdata),
        .raddr_a(ram_cpu_addr), .rdata_a(ram_cpu_rdata),
        .raddr_b(ram_vid_addr), .rdata_b(ram_vid_rdata)
    );

    exattr_ctrl #(.OFF_W(OFF_W), .UPPER_W(UPPER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_frame(in_frame),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .ram_rdata(ram_cpu_rdata), .ram_we(ram_we), .ram_addr(ram_cpu_addr),
        .ram_wdata(ram_wdata), .mode(mode), .upper(upper),
        .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe)
    );

    exattr_fetch #(.OFF_W(OFF_W), .UPPER_W(UPPER_W), .NUM_BANKS(NUM_BANKS), .VADDR_W(VADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .mode(mode), .upper(upper),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .ram_rdata(ram_vid_rdata), .ram_addr(ram_vid_addr),
        .mem_addr(mem_addr), .mem_ext(mem_ext), .mem_rdata(mem_rdata),
        .fetch_rdata(fetch_rdata), .fetch_rvalid(fetch_rvalid)
    );
endmodule

// File: rtl/exattr_subst_chk.sv
`timescale 1ns/1ps
module exattr_subst_chk #(
    parameter int NUM_BANKS = 32,
    parameter int BANK_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_frame,
    input logic              fetch_valid,
    input logic [1:0]        fa_hi,
    input logic [9:0]        fa_off,
    input logic [1:0]        mode,
    input logic              mem_ext,
    input logic [BANK_W-1:0] mem_bank,
    input logic [7:0]        mem_rdata,
    input logic [7:0]        fetch_rdata,
    input logic              fetch_rvalid,
    input logic              cpu_rd,
    input logic              cpu_sel_reg,
    input logic              cpu_rdata_oe
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!fetch_rvalid && !cpu_rdata_oe));

    assert_nt_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fa_hi == 2'b10 && fa_off < 10'h3C0) |-> !mem_ext);

    assert_bank_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ext |-> (32'(mem_bank) < NUM_BANKS));

    assert_pattern_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ext && fetch_valid) |=> (fetch_rdata == $past(mem_rdata)));

    assert_subst_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ext |-> (mode == 2'd1 && in_frame && fetch_valid));

    assert_open_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_sel_reg && mode < 2'd2) |=> !cpu_rdata_oe);

    assert_readable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_sel_reg && mode >= 2'd2) |=> cpu_rdata_oe);

    assert_rvalid_timing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> fetch_rvalid);

    assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !fetch_rvalid);

    assert_reg_read_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel_reg) |=> !cpu_rdata_oe);
endmodule

bind exattr_subst exattr_subst_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .fetch_valid(fetch_valid),
    .fa_hi(fetch_addr[13:12]), .fa_off(fetch_addr[9:0]), .mode(mode),
    .mem_ext(mem_ext), .mem_bank(mem_addr[MEM_ADDR_W-1:12]), .mem_rdata(mem_rdata),
    .fetch_rdata(fetch_rdata), .fetch_rvalid(fetch_rvalid),
    .cpu_rd(cpu_rd), .cpu_sel_reg(cpu_addr[OFF_W]), .cpu_rdata_oe(cpu_rdata_oe)
);

// File: tb/sim_exattr_subst.sv
`timescale 1ns/1ps
module sim_exattr_subst;
    localparam int NB = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_frame = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [13:0] fetch_addr = '0;
    logic [7:0]  fetch_rdata;
    logic        fetch_rvalid;
    logic [19:0] mem_addr;
    logic        mem_ext;
    logic [7:0]  mem_rdata;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [10:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] model(input logic [19:0] a, input logic e);
        return e ? (a[7:0] ^ a[19:12] ^ 8'h5A) : (a[7:0] ^ {2'b00, a[13:8]});
    endfunction

    assign mem_rdata = model(mem_addr, mem_ext);

    exattr_subst #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .in_frame(in_frame),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_rdata(fetch_rdata), .fetch_rvalid(fetch_rvalid),
        .mem_addr(mem_addr), .mem_ext(mem_ext), .mem_rdata(mem_rdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe)
    );

    // {ram byte[31:24], upper[23:22], tile offset[21:12], pattern address[11:0]}
    localparam logic [31:0] VEC [6] = '{
        {8'hC5, 2'd1, 10'h045, 12'h7A3},
        {8'h3F, 2'd0, 10'h3BF, 12'h000},
        {8'h4A, 2'd3, 10'h000, 12'hFFF},
        {8'h80, 2'd2, 10'h1F0, 12'h123},
        {8'hE1, 2'd0, 10'h2A7, 12'h800},
        {8'h1E, 2'd2, 10'h3A0, 12'h0F0}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [10:0] a, output logic oe, output logic [7:0] d);
        @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk); cpu_rd = 1'b0; oe = cpu_rdata_oe; d = cpu_rdata;
    endtask

    task automatic fetch(input logic [13:0] a, output logic [7:0] d, output logic rv,
                         output logic [19:0] ma, output logic me);
        @(negedge clk); fetch_valid = 1'b1; fetch_addr = a;
        #1; ma = mem_addr; me = mem_ext;
        @(negedge clk); fetch_valid = 1'b0; d = fetch_rdata; rv = fetch_rvalid;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d; logic rv, me, oe; logic [19:0] ma;
        repeat (3) @(negedge clk);
        check("R1 rvalid in reset", int'(fetch_rvalid), 0);
        check("R1 rdata in reset", int'(fetch_rdata), 0);
        check("R1 oe in reset", int'(cpu_rdata_oe), 0);
        rst_n = 1'b1;
        cpu_read(11'h010, oe, d);
        check("R1 mode 0 after reset gives open bus", int'(oe), 0);

        // Table of vectors
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v; logic [1:0] up; logic [9:0] off; logic [11:0] pa;
            logic [13:0] nt; logic [7:0] bank; logic [1:0] p;
            {v, up, off, pa} = VEC[i];
            bank = 8'(int'({up, v[5:0]}) % NB);
            p = v[7:6];
            nt = 14'h2000 | 14'(int'(i % 4) << 10) | 14'(off);
            in_frame = 1'b0;
            cpu_write(11'h400, 8'd2);
            cpu_write({1'b0, off}, v);
            cpu_write(11'h401, {6'd0, up});
            cpu_write(11'h400, 8'd1);
            in_frame = 1'b1;
            fetch(nt, d, rv, ma, me);
            check("R2 nt passthrough ext", int'(me), 0);
            check("R2 nt passthrough data", int'(d), int'(model(20'(nt), 1'b0)));
            check("R10 rvalid after fetch", int'(rv), 1);
            fetch(14'h23C0 + 14'(i), d, rv, ma, me);
            check("R3 palette byte", int'(d), int'({p, p, p, p}));
            fetch(14'(pa), d, rv, ma, me);
            check("R4 R11 bank address", int'(ma), int'({bank, pa}));
            check("R5 pattern ext", int'(me), 1);
            check("R5 pattern data", int'(d), int'(model({bank, pa}, 1'b1)));
            fetch(14'h1000 | 14'(pa), d, rv, ma, me);
            check("R5 second pattern address", int'(ma), int'({bank, pa}));
            check("R5 second pattern data", int'(d), int'(model({bank, pa}, 1'b1)));
            fetch(14'h0ABC, d, rv, ma, me);
            check("R5 fourth fetch passes", int'(me), 0);
            check("R5 fourth fetch data", int'(d), int'(model(20'h00ABC, 1'b0)));
        end

        // An address outside the nametable window counts as non-nametable
        fetch(14'h2045, d, rv, ma, me);
        fetch(14'h3000, d, rv, ma, me);
        check("R2 0x3000 takes palette step", int'(d), 32'hFF);
        fetch(14'h23C5, d, rv, ma, me);
        check("R2 attribute address does not reload", int'(me), 1);

        // Inactive: mode 1 out of frame, mode 2 in frame
        in_frame = 1'b0;
        fetch(14'h2045, d, rv, ma, me);
        fetch(14'h23C0, d, rv, ma, me);
        check("R6 out of frame passthrough", int'(d), int'(model(20'h023C0, 1'b0)));
        fetch(14'h0123, d, rv, ma, me);
        check("R6 out of frame no ext", int'(me), 0);
        in_frame = 1'b1;
        cpu_write(11'h400, 8'd2);
        fetch(14'h2045, d, rv, ma, me);
        fetch(14'h23C0, d, rv, ma, me);
        check("R6 mode 2 passthrough", int'(d), int'(model(20'h023C0, 1'b0)));

        // CPU RAM access rules
        cpu_write(11'h400, 8'd0);
        in_frame = 1'b0;
        cpu_write(11'h010, 8'h77);
        in_frame = 1'b1;
        cpu_write(11'h011, 8'h66);
        cpu_read(11'h011, oe, d);
        check("R7 mode 0 read open bus", int'(oe), 0);
        cpu_write(11'h400, 8'd1);
        cpu_read(11'h011, oe, d);
        check("R7 mode 1 read open bus", int'(oe), 0);
        cpu_write(11'h400, 8'd2);
        cpu_read(11'h010, oe, d);
        check("R7 write out of frame stores zero", int'(d), 0);
        cpu_read(11'h011, oe, d);
        check("R7 write in frame stores data", int'(d), 32'h66);
        check("R8 mode 2 read drives", int'(oe), 1);
        cpu_write(11'h012, 8'h3C);
        cpu_read(11'h012, oe, d);
        check("R8 mode 2 write and read", int'(d), 32'h3C);
        cpu_write(11'h400, 8'd3);
        cpu_write(11'h011, 8'h99);
        cpu_read(11'h011, oe, d);
        check("R9 mode 3 write ignored", int'(d), 32'h66);
        check("R9 mode 3 read drives", int'(oe), 1);
        cpu_read(11'h400, oe, d);
        check("R11 register read open bus", int'(oe), 0);

        // Reset in the middle of a sequence clears the countdown
        cpu_write(11'h400, 8'd1);
        fetch(14'h2045, d, rv, ma, me);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 rvalid cleared by reset", int'(fetch_rvalid), 0);
        rst_n = 1'b1;
        cpu_write(11'h400, 8'd1);
        fetch(14'h23C0, d, rv, ma, me);
        check("R1 countdown cleared", int'(d), int'(model(20'h023C0, 1'b0)));
        @(negedge clk);
        check("R10 rvalid drops when idle", int'(fetch_rvalid), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule